// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a parameterised number of asynchronous external request inputs and presents them to a processor as one combined interrupt. It has a small word-addressed register port. Each line has its own trigger setting, chosen from three per-line bit registers. The first picks edge or level sensing. The second gives the edge direction. The third gives the active level.

Every input passes through a two-stage synchroniser before any sensing takes place. On an edge-sensed line, a qualifying transition sets a sticky pending bit, and software later clears that bit by writing a one to the acknowledge register. On a level-sensed line, the pending bit tracks the polarity-adjusted input.

Software turns lines on with one write-one register and off with another, and it reads the resulting enable state from a third. The interrupt output is high whenever some line is both pending and enabled. Configuration bits above the implemented line count cannot be written and read as zero. Software can therefore find the line count by writing all ones and reading back.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset all configuration, enable and pending bits are zero, every register reads zero and `irq_out` is low.
- R2: The word addresses are as follows. 0 is the trigger kind (1 = level, 0 = edge). 1 is the edge direction (1 = rising, 0 = falling). 2 is the level polarity (1 = high, 0 = low). 3 is enable-set and 4 is enable-clear, both write-only. 5 is the enable state and 6 is pending, both read-only. 7 is acknowledge, write-only. Write-only addresses read zero. Registers at addresses 0 to 2 keep only bits below NUM_LINES, and every bit at or above NUM_LINES reads zero.
- R3: With trigger kind 0 and edge direction 0, a 1-to-0 transition of a line sets its pending bit, and a 0-to-1 transition does not.
- R4: With trigger kind 0 and edge direction 1, a 0-to-1 transition sets the pending bit, and a 1-to-0 transition does not.
- R5: With trigger kind 1, the pending bit equals (input == level polarity bit), sampled through the synchroniser.
- R6: On an edge line, writing 1 to an acknowledge bit clears that pending bit, and 0 bits leave it unchanged. If a new edge arrives in the same cycle as the acknowledge, the bit stays set.
- R7: On a level line, an acknowledge write does not clear the pending bit while the level is still active.
- R8: Writing 1 to a bit of enable-set turns that line on, and writing 1 to a bit of enable-clear turns it off. Bits written as 0 change nothing. The enable state register returns the current enables.
- R9: Pending bits are set regardless of whether the line is enabled.
- R10: `irq_out` is high exactly when some line is both pending and enabled.
- R11: A change at an input reaches the pending register on the third rising clock edge after it is presented, and not sooner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| ext_in | input | NUM_LINES | Asynchronous external request inputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is an acknowledge write that lands in the same clock edge in which a new edge sets the same pending bit. Set wins in that case. To land it, the bench drives the input transition and waits exactly two edges for the synchroniser. It then issues the acknowledge write so that it is captured on the third edge. A second hard case is a switch of a line from edge to level sensing while its input is already at the active level. The pending bit must then appear one edge after the configuration write. The bench produces this by holding a line low and then writing the level-low setting.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_KIND  = 3'd0,
    RA_EPOL  = 3'd1,
    RA_LPOL  = 3'd2,
    RA_ENSET = 3'd3,
    RA_ENCLR = 3'd4,
    RA_ENMSK = 3'd5,
    RA_STAT  = 3'd6,
    RA_ACK   = 3'd7
  } reg_addr_e;

  // transition of the synchronised sample in the chosen direction
  function automatic logic edge_event(input logic cur, input logic prev,
                                      input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

  // input matches the selected active level
  function automatic logic level_active(input logic cur, input logic hi);
    return ~(cur ^ hi);
  endfunction

  // next pending value for one line
  function automatic logic next_pending(input logic is_level, input logic cur_pend,
                                        input logic ack, input logic hit,
                                        input logic lvl);
    if (is_level) return lvl;
    return hit | (cur_pend & ~ack);
  endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] trig_kind,
  input  logic [WIDTH-1:0] edge_rise,
  input  logic [WIDTH-1:0] lvl_high,
  input  logic [WIDTH-1:0] ack_stb,
  output logic [WIDTH-1:0] edge_hit,
  output logic [WIDTH-1:0] lvl_act,
  output logic [WIDTH-1:0] pend_q
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_line
      assign edge_hit[i] = edge_event(sync_in[i], prev_q[i], edge_rise[i]);
      assign lvl_act[i]  = level_active(sync_in[i], lvl_high[i]);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pend_q[i] <= 1'b0;
        else pend_q[i] <= next_pending(trig_kind[i], pend_q[i], ack_stb[i],
                                       edge_hit[i], lvl_act[i]);
    end
  endgenerate
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [WIDTH-1:0]  pend_q,
  output logic [WIDTH-1:0]  trig_q,
  output logic [WIDTH-1:0]  epol_q,
  output logic [WIDTH-1:0]  lpol_q,
  output logic [WIDTH-1:0]  en_q,
  output logic [WIDTH-1:0]  ack_stb,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [WIDTH-1:0] wbits;
  logic             wr_kind, wr_epol, wr_lpol, wr_set, wr_clr, wr_ack;

  assign wbits   = reg_wdata[WIDTH-1:0];
  assign wr_kind = reg_wr && (reg_addr == RA_KIND);
  assign wr_epol = reg_wr && (reg_addr == RA_EPOL);
  assign wr_lpol = reg_wr && (reg_addr == RA_LPOL);
  assign wr_set  = reg_wr && (reg_addr == RA_ENSET);
  assign wr_clr  = reg_wr && (reg_addr == RA_ENCLR);
  assign wr_ack  = reg_wr && (reg_addr == RA_ACK);
  assign ack_stb = wr_ack ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trig_q <= '0;
      epol_q <= '0;
      lpol_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_kind) trig_q <= wbits;
      if (wr_epol) epol_q <= wbits;
      if (wr_lpol) lpol_q <= wbits;
      if (wr_set)  en_q   <= en_q | wbits;
      else if (wr_clr) en_q <= en_q & ~wbits;
    end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_KIND:  reg_rdata = DATA_W'(trig_q);
      RA_EPOL:  reg_rdata = DATA_W'(epol_q);
      RA_LPOL:  reg_rdata = DATA_W'(lpol_q);
      RA_ENMSK: reg_rdata = DATA_W'(en_q);
      RA_STAT:  reg_rdata = DATA_W'(pend_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_LINES-1:0] ext_in,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] sync_v, trig_q, epol_q, lpol_q, en_q, ack_stb;
  logic [NUM_LINES-1:0] edge_hit, lvl_act, pend_q, live_req;

  extirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in), .sync_out(sync_v));

  extirq_detect #(.WIDTH(NUM_LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_v), .trig_kind(trig_q),
    .edge_rise(epol_q), .lvl_high(lpol_q), .ack_stb(ack_stb),
    .edge_hit(edge_hit), .lvl_act(lvl_act), .pend_q(pend_q));

  extirq_regs #(.WIDTH(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pend_q(pend_q), .trig_q(trig_q),
    .epol_q(epol_q), .lpol_q(lpol_q), .en_q(en_q), .ack_stb(ack_stb),
    .reg_rdata(reg_rdata));

  assign live_req = pend_q & en_q;
  assign irq_out  = |live_req;
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] trig_q,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] lvl_act
);
  logic [NUM_LINES-1:0] wb;
  assign wb = reg_wdata[NUM_LINES-1:0];

  assert_kind_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_KIND) |=> (trig_q == $past(wb)));

  assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_ENSET) |=> ((en_q & $past(wb)) == $past(wb)));

  assert_enable_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_ENCLR) |=> ((en_q & $past(wb)) == '0));

  // R3 and R4: a detected edge on an edge line is latched
  assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_hit & ~trig_q)) |=>
      ((pend_q & $past(edge_hit & ~trig_q)) == $past(edge_hit & ~trig_q)));

  assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == RA_ACK) |=>
      (($past(pend_q & ~trig_q) & ~trig_q & ~pend_q) == '0));

  assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_q ^ $past(lvl_act)) & $past(trig_q)) == '0));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((pend_q != '0) && (en_q != '0)));
endmodule

bind extirq_ctrl extirq_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_out(irq_out), .trig_q(trig_q), .en_q(en_q),
  .pend_q(pend_q), .edge_hit(edge_hit), .lvl_act(lvl_act));

// File: tb/sim_extirq_ctrl.sv
`timescale 1ns/1ps
module sim_extirq_ctrl;
  localparam int N  = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  ext_in = '0;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  extirq_ctrl #(.NUM_LINES(N), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
    .irq_out(irq_out));

  // behavioural reference: one entry per line
  bit m_s1[N], m_s2[N], m_prev[N], m_pend[N];
  bit m_kind[N], m_epol[N], m_lpol[N], m_en[N];

  function automatic int pack(input bit v[N]);
    int r = 0;
    for (int i = 0; i < N; i++) if (v[i]) r += (1 << i);
    return r;
  endfunction

  function automatic logic [DW-1:0] model_read(input int a);
    case (a)
      0: return pack(m_kind);
      1: return pack(m_epol);
      2: return pack(m_lpol);
      5: return pack(m_en);
      6: return pack(m_pend);
      default: return 0;
    endcase
  endfunction

  function automatic bit model_irq();
    for (int i = 0; i < N; i++) if (m_pend[i] && m_en[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
        m_kind[i] = 0; m_epol[i] = 0; m_lpol[i] = 0; m_en[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit ackb, hit;
        ackb = reg_wr && reg_addr == 3'd7 && reg_wdata[i];
        if (m_kind[i]) m_pend[i] = (m_s2[i] == m_lpol[i]);
        else begin
          hit = m_epol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
          if (hit) m_pend[i] = 1;
          else if (ackb) m_pend[i] = 0;
        end
        m_prev[i] = m_s2[i];
        m_s2[i]   = m_s1[i];
        m_s1[i]   = ext_in[i];
        if (reg_wr) begin
          case (reg_addr)
            3'd0: m_kind[i] = reg_wdata[i];
            3'd1: m_epol[i] = reg_wdata[i];
            3'd2: m_lpol[i] = reg_wdata[i];
            3'd3: if (reg_wdata[i]) m_en[i] = 1;
            3'd4: if (reg_wdata[i]) m_en[i] = 0;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // every clock: output and read port against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 irq_out per cycle", {31'd0, irq_out}, {31'd0, model_irq()});
      check("R2 read port per cycle", reg_rdata, model_read(int'(reg_addr)));
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string req);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 0, "R1 reset read");
    check("R1 irq after reset", {31'd0, irq_out}, 0);

    // R2 writable width, line count discovery
    wr(3'd2, '1); rd(3'd2, 32'hF, "R2 level polarity width");
    wr(3'd0, '1); rd(3'd0, 32'hF, "R2 kind width");
    wr(3'd1, '1); rd(3'd1, 32'hF, "R2 edge dir width");
    rd(3'd3, 0, "R2 write-only reads zero");
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0);
    rd(3'd6, 0, "R2 no pending after config");

    // R3 falling default, R11 latency
    ext_in[0] = 1; tick(4);
    rd(3'd6, 0, "R3 rising ignored");
    ext_in[0] = 0; tick(2);
    rd(3'd6, 0, "R11 not before third edge");
    tick(1);
    rd(3'd6, 1, "R3 R11 falling latched on third edge");
    check("R9 pending while disabled, irq low", {31'd0, irq_out}, 0);

    // R8 enables, R10 output
    wr(3'd3, 0); rd(3'd5, 0, "R8 zero set bits no effect");
    wr(3'd3, 1); rd(3'd5, 1, "R8 enable set");
    check("R10 irq high", {31'd0, irq_out}, 1);
    wr(3'd4, 2); rd(3'd5, 1, "R8 clear other line no effect");
    wr(3'd4, 1); rd(3'd5, 0, "R8 enable clear");
    check("R10 irq low after disable", {31'd0, irq_out}, 0);
    wr(3'd3, 1);

    // R6 acknowledge
    wr(3'd7, 0); rd(3'd6, 1, "R6 zero ack no effect");
    wr(3'd7, 1); rd(3'd6, 0, "R6 ack clears");
    check("R10 irq low after ack", {31'd0, irq_out}, 0);

    // R4 rising
    wr(3'd1, 2);
    ext_in[1] = 1; tick(3);
    rd(3'd6, 2, "R4 rising latched");
    wr(3'd7, 2);
    ext_in[1] = 0; tick(4);
    rd(3'd6, 0, "R4 falling ignored");

    // R5 R7 level high on line 2
    wr(3'd2, 4); wr(3'd0, 4); tick(2);
    rd(3'd6, 0, "R5 level high inactive");
    ext_in[2] = 1; tick(3);
    rd(3'd6, 4, "R5 level high active");
    wr(3'd7, 4); rd(3'd6, 4, "R7 ack ignored while active");
    ext_in[2] = 0; tick(3);
    rd(3'd6, 0, "R5 level released");

    // R5 level low on line 3, input already low
    wr(3'd0, 32'hC); tick(1);
    rd(3'd6, 8, "R5 level low active");
    ext_in[3] = 1; tick(3);
    rd(3'd6, 0, "R5 level low released");
    wr(3'd0, 0);

    // R6 ack and edge in the same cycle
    ext_in[0] = 1; tick(4);
    ext_in[0] = 0; tick(2);
    wr(3'd7, 1);
    rd(3'd6, 1, "R6 edge wins over ack");
    check("R10 irq with set win", {31'd0, irq_out}, 1);
    wr(3'd7, 1); rd(3'd6, 0, "R6 later ack clears");
    tick(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule